// File: doc/BRIEF.md
# Video Route Control Slave with I2C Interface

This block is the digital control side of a video routing switch. An I2C master writes four control bytes in one transaction, one for each output path: three composite outputs and one luminance/chrominance (Y/C) output. A three-bit select field taken from each byte is turned into a one-hot select vector that drives the downstream analog multiplexer for that path. A one-byte status read reports a sticky power-on flag, the state of a sync-present input and the resolved levels of two three-level sense inputs.

SCL and SDA are sampled on a fast system clock. Each passes through a two-flop synchronizer and a small glitch filter before START, STOP and bit edges are decoded. SDA is driven open-drain style: the block only ever pulls the line low, through an output-enable. The low bit of the 7-bit slave address comes from an address-select pin, so two such blocks can share one bus.

Top module: `vr_i2c_router`

## Requirements
- R1: The block answers only the address byte 1001 00A R/W, where A is `addr_sel`, which gives write addresses 0x90 and 0x92. Any other address is NACKed and changes nothing.
- R2: In a write, data bytes one to four are ACKed and load, in that order, the controls of composite paths 1, 2 and 3 and of the Y/C path.
- R3: Only bits 5:3 of a control byte matter. For a composite path, code k drives bit k of that path's select vector, and only that bit. Bit 0 means mute; code 1 to 7 selects input 1 to 7.
- R4: For the Y/C path, code 0 drives `yc_sel` = 001 (mute), code 1 drives 010 (pair 1) and code 2 drives 100 (pair 2). Codes 3 to 7 drive 001 (mute).
- R5: After reset every path is muted (`cvN_sel` = 0x01, `yc_sel` = 001) and `sda_oe` is low.
- R6: A read with R/W=1 returns one status byte: bit 7 is the power-on flag, bit 5 is `sync_present`, bit 3 is S1 open, bit 2 is S1 select, bit 1 is S2 open and bit 0 is S2 select. Bits 6 and 4 read 0.
- R7: The power-on flag reads 1 in the first status read after reset and 0 in every read after that.
- R8: A sense level input resolves as follows: 00 (low) gives open=0 and select=1, 01 (middle) gives open=0 and select=0, and 1x (high) gives open=1 and select=0.
- R9: Data bytes after the fourth in a write are NACKed and leave every path unchanged.
- R10: A STOP before all four bytes keeps the bytes already written. The remaining paths keep their earlier values.
- R11: `sda_oe` changes only while SCL is low, and the select outputs change only while the block is acknowledging a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | Pulls SDA low when high |
| addr_sel | input | 1 | Low address bit of the slave address |
| sync_present | input | 1 | Sync detector result |
| s1_level | input | 2 | Sense input 1 level: 00 low, 01 middle, 1x high |
| s2_level | input | 2 | Sense input 2 level, same encoding |
| cv1_sel | output | 8 | One-hot select for composite path 1 (bit 0 mute) |
| cv2_sel | output | 8 | One-hot select for composite path 2 |
| cv3_sel | output | 8 | One-hot select for composite path 3 |
| yc_sel | output | 3 | One-hot select for the Y/C path (bit 0 mute) |

## Verification
The assertions check on every cycle that each select vector stays one-hot, that SDA is only driven or released while SCL is low, and that a route changes only while a byte is being acknowledged. The address match, the byte-to-path order, the code decoding, the sticky power-on flag, the sense level decoding, the NACK of extra bytes and the survival of partial writes depend on whole transactions. Only the bench scenarios can show them: the bench drives random and directed bus traffic and compares the results against expected values it computes itself.

// File: rtl/vr_pkg.sv
// Shared constants, types and helper functions for the video route slave.
// Assumes control bytes carry the route code in a fixed three-bit field.
package vr_pkg;
    localparam int CTRL_BYTES = 4;
    localparam int FIELD_LSB  = 3;
    localparam int FIELD_W    = 3;
    localparam int CV_CODES   = 1 << FIELD_W;
    localparam int YC_CODES   = 3;
    localparam logic [5:0] ADDR_HI = 6'b100100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
    } bus_state_t;

    // Resolve a three-level sense reading into {open, select}.
    function automatic logic [1:0] sense_decode(input logic [1:0] lvl);
        if (lvl[1])
            return 2'b10;
        else if (lvl[0])
            return 2'b00;
        else
            return 2'b01;
    endfunction
endpackage

// File: rtl/vr_line_filter.sv
// Synchronizes one bus line and suppresses pulses shorter than FILT_LEN
// clocks. The output starts high, which is the idle level of the bus.
module vr_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [CW-1:0]          cnt;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '1;
        else
            chain <= {chain[SYNC_STAGES-2:0], raw};
    end

    // Accept a new level only after it has held for FILT_LEN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt   <= '0;
        end else if (chain[SYNC_STAGES-1] == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
            clean <= chain[SYNC_STAGES-1];
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vr_bus_engine.sv
// I2C slave protocol engine on filtered SCL/SDA. It matches the address,
// ACKs up to NUM_REGS written bytes and emits their route fields, and it
// shifts out one status byte in a read. Assumes SDA only changes while SCL
// is low, except at START and STOP.
module vr_bus_engine
    import vr_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl,
    input  logic                        sda,
    input  logic                        addr_sel,
    input  logic [7:0]                  status_byte,
    output logic                        sda_oe,
    output logic                        wr_en,
    output logic [$clog2(NUM_REGS)-1:0] wr_idx,
    output logic [FIELD_W-1:0]          wr_field,
    output logic                        status_taken
);
    localparam int IDXW = $clog2(NUM_REGS);
    localparam int CNTW = $clog2(NUM_REGS + 1);

    bus_state_t      state;
    logic            scl_q, sda_q;
    logic [7:0]      shreg, tx;
    logic [3:0]      bits;
    logic [CNTW-1:0] idx;
    logic            rw, do_ack;
    logic            scl_rise, scl_fall, start_c, stop_c;

    // Decode bus events from the filtered lines and their previous values.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start_c  = scl & scl_q & sda_q & ~sda;
        stop_c   = scl & scl_q & ~sda_q & sda;
    end

    // Register the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            shreg        <= '0;
            tx           <= '0;
            bits         <= '0;
            idx          <= '0;
            rw           <= 1'b0;
            do_ack       <= 1'b0;
            wr_en        <= 1'b0;
            wr_idx       <= '0;
            wr_field     <= '0;
            status_taken <= 1'b0;
        end else begin
            wr_en        <= 1'b0;
            status_taken <= 1'b0;
            if (start_c) begin
                state <= ST_ADDR;
                bits  <= '0;
                idx   <= '0;
            end else if (stop_c) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda};
                            bits  <= bits + 1'b1;
                        end else if (scl_fall && bits == 4'd8) begin
                            if (shreg[7:1] == {ADDR_HI, addr_sel}) begin
                                rw    <= shreg[0];
                                state <= ST_AACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bits <= '0;
                            if (rw) begin
                                tx           <= status_byte;
                                status_taken <= 1'b1;
                                state        <= ST_RBYTE;
                            end else begin
                                state <= ST_WBYTE;
                            end
                        end
                    end
                    ST_WBYTE: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda};
                            bits  <= bits + 1'b1;
                        end else if (scl_fall && bits == 4'd8) begin
                            if (idx < CNTW'(NUM_REGS)) begin
                                wr_en    <= 1'b1;
                                wr_idx   <= idx[IDXW-1:0];
                                wr_field <= shreg[FIELD_LSB +: FIELD_W];
                                idx      <= idx + 1'b1;
                                do_ack   <= 1'b1;
                            end else begin
                                do_ack <= 1'b0;
                            end
                            state <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            bits  <= '0;
                            state <= ST_WBYTE;
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_fall) begin
                            tx   <= {tx[6:0], 1'b0};
                            bits <= bits + 1'b1;
                            if (bits == 4'd7)
                                state <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall)
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Pull SDA low for acknowledges and for zero bits of the status byte.
    always_comb begin
        sda_oe = (state == ST_AACK) ||
                 (state == ST_WACK && do_ack) ||
                 (state == ST_RBYTE && !tx[7]);
    end
endmodule

// File: rtl/vr_route_decode.sv
// Turns a three-bit route code into a one-hot select of CODES bits.
// Codes at or above CODES fall back to bit 0, which is mute.
module vr_route_decode
    import vr_pkg::*;
#(
    parameter int CODES = 8
) (
    input  logic [FIELD_W-1:0] code,
    output logic [CODES-1:0]   sel
);
    // Match the code against every valid value, muting on no match.
    always_comb begin
        sel = '0;
        for (int k = 0; k < CODES; k++)
            sel[k] = (32'(code) == k);
        if (sel == '0)
            sel[0] = 1'b1;
    end
endmodule

// File: rtl/vr_i2c_router.sv
// Top of the video route slave: filters the bus lines, runs the protocol
// engine, holds one route code per output path and decodes them. Assumes
// rst_n is the power-on reset; the status inputs may be asynchronous.
module vr_i2c_router
    import vr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       sync_present,
    input  logic [1:0] s1_level,
    input  logic [1:0] s2_level,
    output logic [7:0] cv1_sel,
    output logic [7:0] cv2_sel,
    output logic [7:0] cv3_sel,
    output logic [2:0] yc_sel
);
    localparam int IDXW  = $clog2(CTRL_BYTES);
    localparam int NUM_CV = CTRL_BYTES - 1;

    logic                scl_f, sda_f;
    logic                wr_en, status_taken, por_q;
    logic [IDXW-1:0]     wr_idx;
    logic [FIELD_W-1:0]  wr_field;
    logic [FIELD_W-1:0]  code_q [CTRL_BYTES];
    logic [4:0]          stat_s1, stat_s2;
    logic [7:0]          status_byte;
    logic [CV_CODES-1:0] cv_sel_w [NUM_CV];

    vr_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl (
        .clk(clk), .rst_n(rst_n), .raw(scl_in), .clean(scl_f));
    vr_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda (
        .clk(clk), .rst_n(rst_n), .raw(sda_in), .clean(sda_f));

    vr_bus_engine #(.NUM_REGS(CTRL_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .addr_sel(addr_sel), .status_byte(status_byte), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_field(wr_field),
        .status_taken(status_taken));

    // Two-flop synchronizer for the status inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_s1 <= '0;
            stat_s2 <= '0;
        end else begin
            stat_s1 <= {sync_present, s1_level, s2_level};
            stat_s2 <= stat_s1;
        end
    end

    // Sticky power-on flag, cleared when a status byte is handed out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            por_q <= 1'b1;
        else if (status_taken)
            por_q <= 1'b0;
    end

    // Assemble the status byte from the flag and the resolved inputs.
    always_comb begin
        status_byte = {por_q, 1'b0, stat_s2[4], 1'b0,
                       sense_decode(stat_s2[3:2]), sense_decode(stat_s2[1:0])};
    end

    // Route code registers, one per output path, muted at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CTRL_BYTES; i++)
                code_q[i] <= '0;
        end else if (wr_en) begin
            code_q[wr_idx] <= wr_field;
        end
    end

    for (genvar g = 0; g < NUM_CV; g++) begin : g_cv
        vr_route_decode #(.CODES(CV_CODES)) u_dec (
            .code(code_q[g]), .sel(cv_sel_w[g]));
    end

    vr_route_decode #(.CODES(YC_CODES)) u_yc (
        .code(code_q[CTRL_BYTES-1]), .sel(yc_sel));

    assign cv1_sel = cv_sel_w[0];
    assign cv2_sel = cv_sel_w[1];
    assign cv3_sel = cv_sel_w[2];
endmodule

// File: rtl/vr_i2c_router_chk.sv
// Protocol and output checks for vr_i2c_router, attached by bind.
module vr_i2c_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic [7:0] cv1_sel,
    input logic [7:0] cv2_sel,
    input logic [7:0] cv3_sel,
    input logic [2:0] yc_sel
);
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    assert_route_in_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cv1_sel, cv2_sel, cv3_sel, yc_sel}) |-> sda_oe);

    assert_cv_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cv1_sel) == 1) && ($countones(cv2_sel) == 1) &&
        ($countones(cv3_sel) == 1));

    assert_yc_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(yc_sel) == 1);
endmodule

bind vr_i2c_router vr_i2c_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .cv1_sel(cv1_sel), .cv2_sel(cv2_sel), .cv3_sel(cv3_sel), .yc_sel(yc_sel));

// File: tb/vr_i2c_router_test.sv
// Bench for vr_i2c_router: bit-banged I2C master, random and directed traffic.
module vr_i2c_router_test;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       addr_sel = 1'b0, sync_present = 1'b0;
    logic [1:0] s1_level = 2'b00, s2_level = 2'b00;
    logic       sda_oe;
    logic [7:0] cv1_sel, cv2_sel, cv3_sel;
    logic [2:0] yc_sel;
    wire        sda_line = sda_m & ~sda_oe;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [2:0] model [4];

    always #10 clk = ~clk;

    vr_i2c_router uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .sync_present(sync_present),
        .s1_level(s1_level), .s2_level(s2_level), .cv1_sel(cv1_sel),
        .cv2_sel(cv2_sel), .cv3_sel(cv3_sel), .yc_sel(yc_sel));

    function automatic logic [7:0] exp_cv(input logic [2:0] c);
        return 8'(1) << c;
    endfunction

    function automatic logic [2:0] exp_yc(input logic [2:0] c);
        return (c < 3) ? (3'(1) << c) : 3'b001;
    endfunction

    function automatic logic [1:0] exp_sense(input logic [1:0] l);
        case (l)
            2'b00:   return 2'b01;
            2'b01:   return 2'b00;
            default: return 2'b10;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_routes(input string req);
        check(req, {24'd0, cv1_sel}, {24'd0, exp_cv(model[0])});
        check(req, {24'd0, cv2_sel}, {24'd0, exp_cv(model[1])});
        check(req, {24'd0, cv3_sel}, {24'd0, exp_cv(model[2])});
        check(req, {29'd0, yc_sel}, {29'd0, exp_yc(model[3])});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_clk(2*Q);
        sda_m = 1'b0; wait_clk(2*Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(2*Q);
        sda_m = 1'b1; wait_clk(2*Q);
    endtask

    task automatic bus_bit(input logic b, output logic s);
        wait_clk(Q); sda_m = b; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        s = sda_line; wait_clk(Q);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(1'b1, s);
    endtask

    task automatic write_regs(input logic a, input logic [7:0] b [4], input int n);
        logic ak;
        bus_start();
        send_byte({6'b100100, a, 1'b0}, ak);
        check("R1 addr ack", {31'd0, ak}, 32'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(b[i], ak);
            check("R2 data ack", {31'd0, ak}, 32'd1);
            model[i] = b[i][5:3];
        end
        bus_stop();
    endtask

    task automatic read_status(output logic [7:0] d);
        logic ak;
        bus_start();
        send_byte({6'b100100, addr_sel, 1'b1}, ak);
        check("R6 read addr ack", {31'd0, ak}, 32'd1);
        recv_byte(d);
        bus_stop();
    endtask

    initial begin
        logic [7:0] b [4];
        logic [7:0] st;
        logic ak;
        int seed;
        seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < 4; i++) model[i] = 3'd0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R5: all muted and bus released after reset
        check_routes("R5 reset routes");
        check("R5 reset sda_oe", {31'd0, sda_oe}, 32'd0);

        // R6 R7 R8: first status read carries the power-on flag
        sync_present = 1'b1; s1_level = 2'b00; s2_level = 2'b10;
        wait_clk(10);
        read_status(st);
        check("R7 first read por", {24'd0, st}, {24'd0, 8'b1010_0110});
        read_status(st);
        check("R7 second read por clear", {31'd0, st[7]}, 32'd0);

        // R1: foreign address is NACKed and writes nothing
        bus_start();
        send_byte(8'h94, ak);
        check("R1 foreign addr nack", {31'd0, ak}, 32'd0);
        send_byte(8'h38, ak);
        bus_stop();
        check_routes("R1 foreign addr no effect");
        bus_start();
        send_byte(8'h92, ak);   // addr_sel is 0: 0x92 must be refused
        check("R1 other pin addr nack", {31'd0, ak}, 32'd0);
        bus_stop();

        // R2 R3 R4: random writes with both address settings
        for (int t = 0; t < 14; t++) begin
            addr_sel = t[0];
            for (int i = 0; i < 4; i++) b[i] = 8'($urandom);
            write_regs(addr_sel, b, 4);
            wait_clk(4);
            check_routes("R2 R3 random write");
        end

        // R4: every Y/C code directed, including invalid ones
        addr_sel = 1'b0;
        for (int c = 0; c < 8; c++) begin
            b[0] = 8'hC7; b[1] = 8'h00; b[2] = 8'h3F; b[3] = {2'b11, c[2:0], 3'b101};
            write_regs(1'b0, b, 4);
            wait_clk(4);
            check("R4 yc code", {29'd0, yc_sel}, {29'd0, exp_yc(c[2:0])});
            check("R3 cv side bits ignored", {24'd0, cv1_sel}, 32'h01);
            check("R3 cv code 7", {24'd0, cv3_sel}, 32'h80);
        end

        // R9: fifth byte is NACKed and changes nothing
        b[0] = 8'h08; b[1] = 8'h10; b[2] = 8'h18; b[3] = 8'h10;
        bus_start();
        send_byte(8'h90, ak);
        for (int i = 0; i < 4; i++) begin
            send_byte(b[i], ak);
            model[i] = b[i][5:3];
        end
        send_byte(8'h28, ak);
        check("R9 extra byte nack", {31'd0, ak}, 32'd0);
        send_byte(8'h30, ak);
        check("R9 sixth byte nack", {31'd0, ak}, 32'd0);
        bus_stop();
        check_routes("R9 extra bytes ignored");

        // R10: STOP after two bytes keeps them and the older others
        b[0] = 8'h38; b[1] = 8'h20;
        write_regs(1'b0, b, 2);
        wait_clk(4);
        check_routes("R10 partial write");

        // R6 R8: status with random sense levels and sync
        for (int t = 0; t < 6; t++) begin
            sync_present = 1'($urandom); s1_level = 2'($urandom); s2_level = 2'($urandom);
            addr_sel = t[0];
            wait_clk(10);
            read_status(st);
            check("R6 R8 status", {24'd0, st},
                  {24'd0, 1'b0, 1'b0, sync_present, 1'b0,
                   exp_sense(s1_level), exp_sense(s2_level)});
        end
        check_routes("R6 read leaves routes");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule